// File: doc/BRIEF.md
# Prescaled Interval/Match Timer Channel

This block is one 16-bit timer channel. A power-of-two prescaler turns the system clock into count steps. A counter moves up or down by one on each step. It either runs free over the full 16-bit range or wraps at a programmable limit. Three comparators watch the count and set sticky status flags. Each wrap also sets one of two flags, and the counting mode picks which one. A masked OR of the status bits drives a single interrupt line.

Software-facing logic sits outside this block and feeds it level inputs: the prescaler setting, the wrap limit, the three compare values and the interrupt mask. It also writes a 6-bit control word through a one-cycle write strobe. Writing the control word with its zeroing bit set restarts the count. A separate one-cycle strobe clears the status flags.

Top module: `ptimer_channel`

## Requirements
- R1: After reset the count is 0, all status bits are 0, the interrupt line is low, and the control readback is 0x21, meaning halted with the spare bit set.
- R2: The clock setting has an enable in bit 0 and a shift N in bits 4:1. When enabled, the count makes one step every 2^(N+1) clocks. When disabled, it steps on every clock.
- R3: The control word has halt in bit 0, limit mode in bit 1, count down in bit 2, compare enable in bit 3, zeroing in bit 4 and a spare bit in bit 5. A control write stores every bit except bit 4, which always reads 0. Writing bit 4 as 1 sets the count to 0 and clears the prescaler divider, so the next step comes one full prescale period later. No step happens in the cycle of a control write.
- R4: In limit mode the count stays within 0 to the limit, inclusive. In free mode it covers 0 to 0xFFFF and ignores the limit value. Counting up wraps from the top back to 0. Counting down wraps from 0 back to the top.
- R5: Each wrap sets status bit 0 in limit mode, or status bit 4 in free mode.
- R6: While compare enable is set, a step that lands on compare value i (i = 0..2) sets status bit i+1. In limit mode, a compare value above the limit never fires. With compare enable clear, no compare flag is set.
- R7: Status bits stay set until the clear strobe. If an event and the clear strobe fall in the same cycle, the event's bit ends up set. Bit 5 is reserved and stays 0.
- R8: The interrupt line is high exactly when some bit of status AND mask is 1. It follows a mask change with no clock delay.
- R9: While halt is set, the count keeps its value and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_cfg | input | 5 | Prescaler enable (bit 0) and shift N (bits 4:1) |
| ctrl_wr | input | 1 | One-cycle control write strobe |
| ctrl_wdata | input | 6 | Control word to write |
| ctrl_rdata | output | 6 | Stored control word (bit 4 always 0) |
| limit_val | input | 16 | Wrap limit used in limit mode |
| match_vals | input | 48 | Three compare values; value i in bits 16i+15:16i |
| irq_mask | input | 6 | Interrupt enable per status bit |
| stat_clr | input | 1 | One-cycle status clear strobe |
| count | output | 16 | Current count |
| status | output | 6 | Sticky status flags |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench checks the downward wrap in limit mode, from 0 to the limit. A design that wrapped to 0xFFFF, or that set the overflow flag instead of the interval flag, shows the wrong count or the wrong status bit. The bench sets one compare value above the limit and disables compares in another phase. A design that ignored either rule raises a compare flag that should stay clear.

The bench also makes a clear strobe coincide with a wrap; a design where the clear wins loses the flag. It restarts the prescaler mid-period; a design that kept the old divider steps early. It stops the count while halted and checks that it holds. It runs a full free-range pass and checks the overflow flag and a compare on 0xFFFF.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int CNT_W    = 16;
    localparam int N_MATCH  = 3;
    localparam int PSC_N_W  = 4;
    localparam int CTRL_W   = 6;
    localparam int ZERO_BIT = 4;

    // control word layout, bit 5 down to bit 0
    typedef struct packed {
        logic spare;
        logic zero;
        logic match_on;
        logic down;
        logic intv_mode;
        logic halt;
    } cnt_ctrl_t;

    localparam cnt_ctrl_t CTRL_RESET = '{spare: 1'b1, zero: 1'b0, match_on: 1'b0,
                                         down: 1'b0, intv_mode: 1'b0, halt: 1'b1};

    typedef struct packed {
        logic [PSC_N_W-1:0] shift;
        logic               on;
    } clk_cfg_t;

    // status bit positions as a function of comparator count
    function automatic int wrap_bit(input logic intv_mode, input int n_match);
        return intv_mode ? 0 : n_match + 1;
    endfunction

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
    parameter int SHIFT_W = ptimer_pkg::PSC_N_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic               div_on,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int DIV_W = (1 << SHIFT_W) + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] limit;
    logic             at_end;

    always_comb begin
        period = DIV_W'(1) << (int'(shift) + 1);
        limit  = period - DIV_W'(1);
        at_end = (div_q >= limit);
        tick   = run && (!div_on || at_end);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (!div_on) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= at_end ? '0 : div_q + DIV_W'(1);
        end
    end

    AST_FULL_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (restart && div_on) ##1 (div_on && !restart) |-> !tick); // R3

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
    parameter int CNT_W = ptimer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             zero,
    input  logic             down,
    input  logic             intv_mode,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top;
    logic             at_edge;

    always_comb begin
        top     = intv_mode ? limit : '1;
        nxt     = cnt_q;
        at_edge = 1'b0;
        if (down) begin
            if (cnt_q == '0) begin
                nxt     = top;
                at_edge = 1'b1;
            end else if (cnt_q > top) begin
                nxt = top;
            end else begin
                nxt = cnt_q - CNT_W'(1);
            end
        end else begin
            if (cnt_q >= top) begin
                nxt     = '0;
                at_edge = 1'b1;
            end else begin
                nxt = cnt_q + CNT_W'(1);
            end
        end
        wrap = step && at_edge;
    end

    always_ff @(posedge clk) begin
        if (rst || zero) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= nxt;
        end
    end

    assign cnt = cnt_q;

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        zero |=> (cnt_q == '0)); // R3
    AST_INTV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (step && intv_mode && !zero) |=> (cnt_q <= $past(limit))); // R4
    AST_UP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (step && !zero && !down && !at_edge) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R4

endmodule

// File: rtl/ptimer_flags.sv
module ptimer_flags #(
    parameter int CNT_W   = ptimer_pkg::CNT_W,
    parameter int N_MATCH = ptimer_pkg::N_MATCH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic                     match_on,
    input  logic                     intv_mode,
    input  logic [CNT_W-1:0]         limit,
    input  logic [CNT_W-1:0]         nxt,
    input  logic                     wrap,
    input  logic [N_MATCH*CNT_W-1:0] match_vals,
    input  logic                     clr,
    input  logic [N_MATCH+2:0]       irq_mask,
    output logic [N_MATCH+2:0]       status,
    output logic                     irq
);
    localparam int ST_W = N_MATCH + 3;

    logic [N_MATCH-1:0] hit;
    logic [ST_W-1:0]    set_v;
    logic [ST_W-1:0]    st_q;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
        logic [CNT_W-1:0] mv;
        assign mv     = match_vals[i*CNT_W +: CNT_W];
        assign hit[i] = step && match_on && (nxt == mv) && (!intv_mode || mv <= limit);
    end

    always_comb begin
        set_v              = '0;
        set_v[N_MATCH:1]   = hit;
        if (wrap) begin
            set_v[ptimer_pkg::wrap_bit(intv_mode, N_MATCH)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= (clr ? '0 : st_q) | set_v;
        end
    end

    assign status = st_q;
    assign irq    = |(st_q & irq_mask);

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((st_q & $past(st_q)) == $past(st_q))); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr && wrap && intv_mode) |=> st_q[0]); // R7
    AST_EVT_RESERVED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !st_q[ST_W-1]); // R7

endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel
    import ptimer_pkg::*;
#(
    parameter int CNT_W   = ptimer_pkg::CNT_W,
    parameter int N_MATCH = ptimer_pkg::N_MATCH,
    parameter int SHIFT_W = ptimer_pkg::PSC_N_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SHIFT_W:0]         clk_cfg,
    input  logic                     ctrl_wr,
    input  logic [CTRL_W-1:0]        ctrl_wdata,
    output logic [CTRL_W-1:0]        ctrl_rdata,
    input  logic [CNT_W-1:0]         limit_val,
    input  logic [N_MATCH*CNT_W-1:0] match_vals,
    input  logic [N_MATCH+2:0]       irq_mask,
    input  logic                     stat_clr,
    output logic [CNT_W-1:0]         count,
    output logic [N_MATCH+2:0]       status,
    output logic                     irq
);
    cnt_ctrl_t        ctrl_q;
    logic             zero_pulse;
    logic             run;
    logic             step;
    logic             wrap;
    logic [CNT_W-1:0] nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_wr) begin
            ctrl_q      <= cnt_ctrl_t'(ctrl_wdata);
            ctrl_q.zero <= 1'b0;
        end
    end

    assign ctrl_rdata = ctrl_q;
    assign zero_pulse = ctrl_wr && ctrl_wdata[ZERO_BIT];
    assign run        = !ctrl_q.halt && !ctrl_wr;

    ptimer_prescaler #(.SHIFT_W(SHIFT_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (zero_pulse),
        .div_on  (clk_cfg[0]),
        .shift   (clk_cfg[SHIFT_W:1]),
        .tick    (step)
    );

    ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .zero      (zero_pulse),
        .down      (ctrl_q.down),
        .intv_mode (ctrl_q.intv_mode),
        .limit     (limit_val),
        .cnt       (count),
        .nxt       (nxt),
        .wrap      (wrap)
    );

    ptimer_flags #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .match_on   (ctrl_q.match_on),
        .intv_mode  (ctrl_q.intv_mode),
        .limit      (limit_val),
        .nxt        (nxt),
        .wrap       (wrap),
        .match_vals (match_vals),
        .clr        (stat_clr),
        .irq_mask   (irq_mask),
        .status     (status),
        .irq        (irq)
    );

    AST_HALT_COUNT: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.halt && !ctrl_wr) |=> $stable(count)); // R9
    AST_HALT_STATUS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.halt && !ctrl_wr && !stat_clr) |=> $stable(status)); // R9
    AST_ZERO_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !ctrl_rdata[ZERO_BIT]); // R3

endmodule

// File: tb/tb_ptimer_channel.sv
module tb_ptimer_channel;
    localparam int CLK_P = 10;

    typedef struct {
        int          cyc;
        logic [15:0] cnt;
        logic [5:0]  st;
        logic        irq;
        logic [5:0]  ctl;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  clk_cfg = '0;
    logic        ctrl_wr = 1'b0;
    logic [5:0]  ctrl_wdata = '0;
    logic [5:0]  ctrl_rdata;
    logic [15:0] limit_val = 16'd4;
    logic [15:0] m0 = 16'd2, m1 = 16'd7, m2 = 16'd3;
    logic [5:0]  irq_mask = 6'h3F;
    logic        stat_clr = 1'b0;
    logic [15:0] count;
    logic [5:0]  status;
    logic        irq;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptimer_channel dut (
        .clk        (clk),
        .rst        (rst),
        .clk_cfg    (clk_cfg),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .limit_val  (limit_val),
        .match_vals ({m2, m1, m0}),
        .irq_mask   (irq_mask),
        .stat_clr   (stat_clr),
        .count      (count),
        .status     (status),
        .irq        (irq)
    );

    task automatic expect_at(input int c, input logic [15:0] cn, input logic [5:0] st,
                             input logic iq, input logic [5:0] ct, input string req);
        item_t it;
        it.cyc = c; it.cnt = cn; it.st = st; it.irq = iq; it.ctl = ct; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        ctrl_wdata = v;
        ctrl_wr    = 1'b1;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic pulse_clr();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    // monitor: compare results as they appear
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if (it.cyc != cyc || count !== it.cnt || status !== it.st ||
                    irq !== it.irq || ctrl_rdata !== it.ctl) begin
                    bad++;
                    $display("FAIL %s at cycle %0d: actual cnt=%h st=%h irq=%b ctl=%h expected cnt=%h st=%h irq=%b ctl=%h",
                             it.req, cyc, count, status, irq, ctrl_rdata,
                             it.cnt, it.st, it.irq, it.ctl);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        expect_at(cyc + 1, 16'd0, 6'h00, 1'b0, 6'h21, "R1 reset state");
        expect_at(cyc + 5, 16'd0, 6'h00, 1'b0, 6'h21, "R9 halted after reset");
        rst = 1'b0;
        wait_until(cyc + 5);

        // up, limit mode 4, compares on, no prescaler
        e = cyc + 1;
        expect_at(e,      16'd0, 6'h00, 1'b0, 6'h0A, "R3 zeroing bit not stored");
        expect_at(e + 1,  16'd1, 6'h00, 1'b0, 6'h0A, "R2 step every clock");
        expect_at(e + 2,  16'd2, 6'h02, 1'b1, 6'h0A, "R6 compare 0 hit");
        expect_at(e + 3,  16'd3, 6'h0A, 1'b1, 6'h0A, "R6 compare 2 hit");
        expect_at(e + 4,  16'd4, 6'h0A, 1'b1, 6'h0A, "R4 reach limit");
        expect_at(e + 5,  16'd0, 6'h0B, 1'b1, 6'h0A, "R5 interval flag on up wrap");
        expect_at(e + 10, 16'd0, 6'h0B, 1'b1, 6'h0A, "R6 compare above limit silent");
        wr_ctrl(6'h1A);
        wait_until(e + 12);
        wr_ctrl(6'h0B);
        expect_at(e + 14, 16'd2, 6'h0B, 1'b1, 6'h0B, "R9 halt holds count");
        wait_until(e + 15);
        irq_mask = 6'h10;
        expect_at(e + 16, 16'd2, 6'h0B, 1'b0, 6'h0B, "R8 mask hides status");
        wait_until(e + 17);
        expect_at(e + 18, 16'd2, 6'h00, 1'b0, 6'h0B, "R7 clear strobe");
        pulse_clr();
        irq_mask = 6'h3F;

        // down, limit mode 3, compares off
        limit_val = 16'd3;
        e = cyc + 1;
        expect_at(e,     16'd0, 6'h00, 1'b0, 6'h06, "R3 control stored");
        expect_at(e + 1, 16'd3, 6'h01, 1'b1, 6'h06, "R4 down wrap to limit");
        expect_at(e + 2, 16'd2, 6'h01, 1'b1, 6'h06, "R6 compare disabled");
        expect_at(e + 5, 16'd3, 6'h01, 1'b1, 6'h06, "R7 event wins over clear");
        expect_at(e + 6, 16'd2, 6'h01, 1'b1, 6'h06, "R7 flag stays");
        wr_ctrl(6'h16);
        wait_until(e + 4);
        pulse_clr();
        wait_until(e + 6);
        wr_ctrl(6'h01);
        expect_at(e + 8, 16'd2, 6'h00, 1'b0, 6'h01, "R7 clear while halted");
        pulse_clr();

        // up, free mode, compares on, full pass
        m0 = 16'h1234; m1 = 16'h2000; m2 = 16'hFFFF;
        e = cyc + 1;
        expect_at(e,           16'h0000, 6'h00, 1'b0, 6'h08, "R3 zeroing write");
        expect_at(e + 100,     16'd100,  6'h00, 1'b0, 6'h08, "R4 limit ignored in free mode");
        expect_at(e + 'h1234,  16'h1234, 6'h02, 1'b1, 6'h08, "R6 compare 0 free mode");
        expect_at(e + 'h2000,  16'h2000, 6'h06, 1'b1, 6'h08, "R6 compare 1 free mode");
        expect_at(e + 'hFFFF,  16'hFFFF, 6'h0E, 1'b1, 6'h08, "R6 compare 2 at top");
        expect_at(e + 'h10000, 16'h0000, 6'h1E, 1'b1, 6'h08, "R5 overflow flag on free wrap");
        wr_ctrl(6'h18);
        wait_until(e + 'h10000);
        wr_ctrl(6'h01);
        expect_at(e + 'h10002, 16'h0000, 6'h00, 1'b0, 6'h01, "R7 clear after pass");
        pulse_clr();

        // prescaler N=1: period 4
        clk_cfg = 5'b00011;
        e = cyc + 1;
        expect_at(e,     16'd0, 6'h00, 1'b0, 6'h00, "R2 prescaler start");
        expect_at(e + 3, 16'd0, 6'h00, 1'b0, 6'h00, "R2 no step before period");
        expect_at(e + 4, 16'd1, 6'h00, 1'b0, 6'h00, "R2 first step after 4 clocks");
        expect_at(e + 7, 16'd1, 6'h00, 1'b0, 6'h00, "R2 hold between steps");
        expect_at(e + 8, 16'd2, 6'h00, 1'b0, 6'h00, "R2 second step");
        wr_ctrl(6'h10);
        wait_until(e + 10);
        expect_at(e + 11, 16'd0, 6'h00, 1'b0, 6'h00, "R3 zero mid period");
        expect_at(e + 14, 16'd0, 6'h00, 1'b0, 6'h00, "R3 divider cleared by zeroing");
        expect_at(e + 15, 16'd1, 6'h00, 1'b0, 6'h00, "R3 full period after zeroing");
        wr_ctrl(6'h10);

        // prescaler N=0: period 2, spare bit kept
        wait_until(e + 16);
        clk_cfg = 5'b00001;
        e = cyc + 1;
        expect_at(e,     16'd0, 6'h00, 1'b0, 6'h20, "R3 spare bit stored");
        expect_at(e + 1, 16'd0, 6'h00, 1'b0, 6'h20, "R2 period 2 hold");
        expect_at(e + 2, 16'd1, 6'h00, 1'b0, 6'h20, "R2 period 2 step");
        expect_at(e + 4, 16'd2, 6'h00, 1'b0, 6'h20, "R2 period 2 next step");
        wr_ctrl(6'h30);

        wait (sb.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule